// File: doc/BRIEF.md
# Serial Port Completion Flag Interrupt Node

This block holds the receive-complete and transmit-complete flags of a serial port and turns them into requests for one node of a simple interrupt controller. Hardware sets a flag with a one-cycle strobe when a character finishes. For receive, that is when its stop bit arrives. Software clears a flag with a one-cycle clear strobe. The two flags are ORed. A low-to-high change of that OR latches a pending request. A level that is already high produces nothing new.

A pending request is dispatched when the node and global enables are both high and no service routine for this node is running. Dispatch marks the node as in service. The node then blocks further dispatch until the core signals return-from-interrupt. Requests latched during service wait and are dispatched after the return.

If a set and a clear hit the same flag in the same cycle, the hardware set wins. When this happens during service, the flag stays high and no edge is seen. No new request is latched and the node goes silent. An optional fix mode re-latches a request at return whenever either flag is still high, which avoids this lockup.

Top module: `serial_irq_node`

## Requirements
- R1: After reset, both flags, the pending request, the in-service state and the request output are 0.
- R2: A completion strobe (rxDone or txDone) sets its flag at the next clock edge, and only that flag.
- R3: A clear strobe drops its flag at the next edge. If the clear and the completion strobe for the same flag are high in the same cycle, the flag is 1 after the edge.
- R4: A pending request is latched one edge after the OR of the two flags changes from 0 to 1. No request is latched while that OR is already high.
- R5: irqReq is high only when a request is pending, nodeEn and globalEn are both 1, and the node is not in service. A pending request is held while the enables are low.
- R6: irqReq lasts a single cycle. At the following edge the node enters service and the pending request is consumed.
- R7: While in service, irqReq stays low and newly latched requests stay pending. reti ends service at the next edge, and a held request is then dispatched.
- R8: With fixMode at 0, a set/clear collision during service leaves the flag high. Such a flag, or a later completion strobe, then produces no request even after reti.
- R9: With fixMode at 1, reti during service latches a pending request if either flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxDone | input | 1 | Receive character complete strobe |
| txDone | input | 1 | Transmit character complete strobe |
| rxClr | input | 1 | Software clear of receive flag |
| txClr | input | 1 | Software clear of transmit flag |
| nodeEn | input | 1 | Node interrupt enable |
| globalEn | input | 1 | Global interrupt enable |
| reti | input | 1 | Return-from-interrupt strobe from the core |
| fixMode | input | 1 | Re-latch a request at return if a flag is high |
| rxFlag | output | 1 | Receive completion flag |
| txFlag | output | 1 | Transmit completion flag |
| irqPending | output | 1 | Latched request awaiting dispatch |
| inService | output | 1 | Service routine of this node active |
| irqReq | output | 1 | Dispatch pulse to the core |

## Verification
A wrong flag update shows on rxFlag or txFlag one edge after the strobe. A missed or extra edge latch shows on irqPending one edge later. A wrong service state shows as an irqReq that is missing, repeated or appears during service. It also shows as a request that is not released at return.

The lockup is driven on purpose and then observed over several idle cycles and further completion strobes. The bench then repeats the same sequence with fix mode on, to show that a request is recovered at return.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int FLAG_COUNT = 2;
  localparam int RX_IDX = 0;
  localparam int TX_IDX = 1;

  typedef struct packed {
    logic dispatch;
    logic relatch;
  } sirqStrobe_t;
endpackage

// File: rtl/sirq_datapath.sv
module sirq_datapath
  import sirq_pkg::*;
#(
  parameter int NFLAG = FLAG_COUNT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NFLAG-1:0] hwSet,
  input  logic [NFLAG-1:0] swClr,
  input  sirqStrobe_t      strobes,
  output logic [NFLAG-1:0] flags,
  output logic             pending,
  output logic             anyFlag
);
  logic prevAny;
  logic anyRise;

  // One flag per completion source; a hardware set wins over a clear.
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= hwSet[i] | (flags[i] & ~swClr[i]);
    end
  end

  assign anyFlag = |flags;
  assign anyRise = anyFlag & ~prevAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAny <= 1'b0;
      pending <= 1'b0;
    end else begin
      prevAny <= anyFlag;
      pending <= (pending & ~strobes.dispatch) | anyRise | strobes.relatch;
    end
  end
endmodule

// File: rtl/sirq_control.sv
module sirq_control
  import sirq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pending,
  input  logic        anyFlag,
  input  logic        nodeEn,
  input  logic        globalEn,
  input  logic        reti,
  input  logic        fixMode,
  output sirqStrobe_t strobes,
  output logic        inService,
  output logic        irqReq
);
  logic retire;

  assign strobes.dispatch = pending & nodeEn & globalEn & ~inService;
  assign retire           = reti & inService;
  assign strobes.relatch  = retire & fixMode & anyFlag;
  assign irqReq           = strobes.dispatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 inService <= 1'b0;
    else if (strobes.dispatch) inService <= 1'b1;
    else if (retire)           inService <= 1'b0;
  end
endmodule

// File: rtl/serial_irq_node.sv
module serial_irq_node
  import sirq_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic rxDone,
  input  logic txDone,
  input  logic rxClr,
  input  logic txClr,
  input  logic nodeEn,
  input  logic globalEn,
  input  logic reti,
  input  logic fixMode,
  output logic rxFlag,
  output logic txFlag,
  output logic irqPending,
  output logic inService,
  output logic irqReq
);
  logic [FLAG_COUNT-1:0] hwSet, swClr, flags;
  logic                  anyFlag;
  sirqStrobe_t           strobes;

  always_comb begin
    hwSet = '0;
    swClr = '0;
    hwSet[RX_IDX] = rxDone;
    hwSet[TX_IDX] = txDone;
    swClr[RX_IDX] = rxClr;
    swClr[TX_IDX] = txClr;
  end

  sirq_datapath #(.NFLAG(FLAG_COUNT)) u_dp (
    .clk(clk), .rstN(rstN), .hwSet(hwSet), .swClr(swClr),
    .strobes(strobes), .flags(flags), .pending(irqPending), .anyFlag(anyFlag)
  );

  sirq_control u_ctl (
    .clk(clk), .rstN(rstN), .pending(irqPending), .anyFlag(anyFlag),
    .nodeEn(nodeEn), .globalEn(globalEn), .reti(reti), .fixMode(fixMode),
    .strobes(strobes), .inService(inService), .irqReq(irqReq)
  );

  assign rxFlag = flags[RX_IDX];
  assign txFlag = flags[TX_IDX];
endmodule

// File: rtl/serial_irq_node_chk.sv
module serial_irq_node_chk (
  input logic clk,
  input logic rstN,
  input logic rxDone,
  input logic txDone,
  input logic reti,
  input logic fixMode,
  input logic rxFlag,
  input logic txFlag,
  input logic irqPending,
  input logic inService,
  input logic irqReq
);
  logic anyF, anyPrevC, roseC;
  assign anyF  = rxFlag | txFlag;
  assign roseC = anyF & ~anyPrevC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) anyPrevC <= 1'b0;
    else       anyPrevC <= anyF;
  end

  // R3
  rx_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN) rxDone |=> rxFlag);
  // R3
  tx_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN) txDone |=> txFlag);
  // R4
  rise_latch_chk: assert property (@(posedge clk) disable iff (!rstN) roseC |=> irqPending);
  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) irqReq |=> (!irqReq && inService));
  // R7
  blocked_chk: assert property (@(posedge clk) disable iff (!rstN) inService |-> !irqReq);
  // R8
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irqPending && !roseC && !(fixMode && reti && inService)) |=> !irqPending);
endmodule

bind serial_irq_node serial_irq_node_chk u_chk (
  .clk(clk), .rstN(rstN), .rxDone(rxDone), .txDone(txDone), .reti(reti),
  .fixMode(fixMode), .rxFlag(rxFlag), .txFlag(txFlag), .irqPending(irqPending),
  .inService(inService), .irqReq(irqReq)
);

// File: tb/test_serial_irq_node.sv
module test_serial_irq_node;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxDone = 0, txDone = 0, rxClr = 0, txClr = 0;
  logic nodeEn = 0, globalEn = 0, reti = 0, fixMode = 0;
  logic rxFlag, txFlag, irqPending, inService, irqReq;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_irq_node i_serial_irq_node (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle();
    rxDone = 0; txDone = 0; rxClr = 0; txClr = 0; reti = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  // bring node back to idle: end service, clear flags, drop pending via gating
  task automatic quiesce();
    idle();
    if (inService) begin reti = 1; tick(); end
    rxClr = 1; txClr = 1; tick();
    tick();
    if (irqPending) begin nodeEn = 1; globalEn = 1; #1; tick(); reti = 1; tick(); end
  endtask

  initial begin
    #1;
    // R1
    chk("R1 rxFlag", rxFlag, 0); chk("R1 txFlag", txFlag, 0);
    chk("R1 pending", irqPending, 0); chk("R1 inService", inService, 0);
    chk("R1 irqReq", irqReq, 0);
    @(posedge clk); #1; rstN = 1;
    tick();

    // R2/R3 sweep: flag index, initial value, set strobe, clear strobe
    for (int f = 0; f < 2; f++)
      for (int init = 0; init < 2; init++)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 2; c++) begin
            rxClr = 1; txClr = 1; tick();
            if (init == 1) begin
              if (f == 0) rxDone = 1; else txDone = 1;
              tick();
            end
            if (f == 0) begin rxDone = logic'(s); rxClr = logic'(c); end
            else        begin txDone = logic'(s); txClr = logic'(c); end
            tick();
            chk(c && s ? "R3 collision" : (c ? "R3 clear" : "R2 set"),
                f == 0 ? rxFlag : txFlag, logic'(s | (init & ~c)));
            chk("R2 other flag", f == 0 ? txFlag : rxFlag, 0);
          end
    quiesce();

    // R5: pending held while gated, for each disabled enable combination
    rxDone = 1; tick(); tick();
    chk("R4 pending after rise", irqPending, 1);
    for (int e = 0; e < 3; e++) begin
      nodeEn = logic'(e[0]); globalEn = logic'(e[1]); #1;
      chk("R5 gated irqReq", irqReq, 0);
      tick();
      chk("R5 pending held", irqPending, 1);
    end
    // R4: second flag rising while OR already high gives no new request
    nodeEn = 1; globalEn = 1; #1;
    chk("R5 enabled irqReq", irqReq, 1);
    tick();
    chk("R6 inService", inService, 1); chk("R6 pending consumed", irqPending, 0);
    chk("R6 single pulse", irqReq, 0);
    txDone = 1; tick(); tick();
    chk("R4 no latch when already high", irqPending, 0);
    reti = 1; tick();
    chk("R7 reti ends service", inService, 0);
    tick();
    chk("R4 still no request", irqReq, 0);
    quiesce();

    // R7: edge during service held, dispatched after reti
    rxDone = 1; tick(); tick(); tick();
    chk("R7 in service", inService, 1);
    rxClr = 1; tick();
    rxDone = 1; tick(); tick();
    chk("R7 pending during service", irqPending, 1);
    chk("R7 blocked", irqReq, 0);
    reti = 1; tick();
    chk("R7 released", inService, 0);
    chk("R7 dispatch after reti", irqReq, 1);
    tick();
    chk("R7 re-entered service", inService, 1);

    // R8: collision during service with fixMode off locks the node
    fixMode = 0;
    rxClr = 1; rxDone = 1; tick();
    chk("R8 flag stuck", rxFlag, 1);
    tick();
    chk("R8 no new pending", irqPending, 0);
    reti = 1; tick();
    for (int k = 0; k < 4; k++) begin
      if (k == 1) rxDone = 1;
      tick();
      chk("R8 lockup no irqReq", irqReq, 0);
      chk("R8 lockup no pending", irqPending, 0);
    end
    quiesce();

    // R9: same collision with fixMode on recovers at reti
    fixMode = 1;
    rxDone = 1; tick(); tick(); tick();
    chk("R9 in service", inService, 1);
    rxClr = 1; rxDone = 1; tick(); tick();
    chk("R9 no pending before reti", irqPending, 0);
    reti = 1; tick();
    chk("R9 relatch pending", irqPending, 1);
    chk("R9 dispatch", irqReq, 1);
    tick();
    chk("R9 serviced", inService, 1);
    // R9: reti with no flag high latches nothing
    rxClr = 1; tick();
    reti = 1; tick(); tick();
    chk("R9 no relatch without flag", irqPending, 0);
    fixMode = 0;

    done = 1;
  end

  initial begin
    for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    #10;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule